// File: doc/BRIEF.md
# Logical Processor Mode Controller

This block keeps track of which of the two hardware threads of a dual-thread core is running. It reports a committed mode: both threads running, only thread 0 running, only thread 1 running, or both halted. It watches one pulse per thread that says the thread has just executed a halt. It also watches one pulse per thread that says an interrupt has been delivered to that thread. From these it works out which threads should be running next. A running thread that halts stops running. A halted thread that receives an interrupt starts running again. A halt from a thread that is already halted is ignored, and so is an interrupt to a thread that is already running.

A change of the running set needs the partitioned queues to be regrouped. They are pooled for a lone thread and split again when both threads run. So the controller never switches its mode on its own. It raises a repartition request and holds the new target internally. It commits the mode only on the edge where the queues report that they have drained. Events that arrive while the request is up update the pending target. The mode committed on the acknowledge therefore reflects every event seen up to and including that cycle.

The controller has two sequencer states. In STEADY it waits for an event that changes the running set, then moves to DRAIN. In DRAIN it holds the request until the drained acknowledge arrives, then commits the target and moves back to STEADY. The mode values are ALL_HALTED, ST0, ST1 and MT. The mode transitions are: MT to ST1 on a halt of thread 0, MT to ST0 on a halt of thread 1, MT to ALL_HALTED on a simultaneous halt of both threads, ST0 or ST1 to MT on an interrupt to the halted thread, ST0 or ST1 to ALL_HALTED on a halt of the lone thread, and ALL_HALTED to ST0, ST1 or MT depending on which threads receive an interrupt.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After a synchronous reset (rst_i high at a clock edge), mode_o is MT (2'b11), active_o is 2'b11 and repart_req_o is low.
- R2: In MT, a halt pulse of thread 0 alone leads to mode ST1 (2'b10), and a halt pulse of thread 1 alone leads to mode ST0 (2'b01).
- R3: In MT, halt pulses from both threads in the same cycle lead to mode ALL_HALTED (2'b00).
- R4: In ST0 or ST1, an interrupt to the halted thread leads to mode MT.
- R5: An interrupt to a thread that is already running has no effect: no request is raised and the mode is unchanged. The same holds for a halt pulse from a thread that is already halted.
- R6: In ST0 or ST1, a halt from the lone running thread leads to ALL_HALTED. In ALL_HALTED, an interrupt to thread 0 alone leads to ST0, an interrupt to thread 1 alone leads to ST1, and interrupts to both lead to MT.
- R7: When events call for a new mode, repart_req_o rises on the clock edge that samples them. It stays high, and mode_o stays unchanged, until an edge that samples drained_i high. On that edge mode_o takes the new value and repart_req_o falls.
- R8: drained_i has no effect while repart_req_o is low.
- R9: Events sampled while repart_req_o is high are applied on top of the pending target. The mode committed on the acknowledge edge includes the events of that same cycle, even when the result equals the old mode.
- R10: active_o bit i is high exactly when thread i is running under the committed mode. The mode codes are ALL_HALTED=2'b00, ST0=2'b01, ST1=2'b10 and MT=2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| halt_i | input | 2 | Per-thread pulse: the thread executed a halt this cycle |
| irq_i | input | 2 | Per-thread pulse: an interrupt is delivered to the thread this cycle |
| drained_i | input | 1 | The partitioned queues have drained and may be regrouped |
| mode_o | output | 2 | Committed mode (ALL_HALTED, ST0, ST1, MT) |
| active_o | output | 2 | Per-thread running flag under the committed mode |
| repart_req_o | output | 1 | Asks the queues to drain and regroup for a pending mode |

## Verification
Every output is driven from registers, so each result appears one edge after the inputs that cause it. An event sampled on edge k raises the request right after edge k. A drained acknowledge sampled on edge m moves mode_o and active_o, and drops the request, right after edge m. The bench drives its inputs on the falling edge. It advances a reference model on the rising edge, using the same inputs, and compares all three outputs on the following falling edge. Every expected value is therefore due exactly one edge after its cause. Directed sequences cover each transition and the ignored-event cases, and a seeded random phase mixes events with acknowledges that arrive late, early or in the same cycle as new events.

// File: rtl/lp_mode_pkg.sv
package lp_mode_pkg;

    localparam int LP_NUM     = 2;
    localparam int MODE_W     = LP_NUM;

    typedef enum logic [MODE_W-1:0] {
        LPM_ALL_HALTED = 2'b00,
        LPM_ST0        = 2'b01,
        LPM_ST1        = 2'b10,
        LPM_MT         = 2'b11
    } lpm_mode_e;

    typedef enum logic {
        SEQ_STEADY = 1'b0,
        SEQ_DRAIN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/lp_run_eval.sv
module lp_run_eval
    import lp_mode_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  lpm_mode_e         base_i,
    input  logic [LP_NUM-1:0] halt_i,
    input  logic [LP_NUM-1:0] irq_i,
    output lpm_mode_e         next_o
);

    logic [LP_NUM-1:0] run_now;
    logic [LP_NUM-1:0] run_next;

    assign run_now = base_i;

    // A running thread keeps running unless it halts; a halted thread
    // resumes only on an interrupt addressed to it.
    for (genvar g = 0; g < LP_NUM; g++) begin : g_thread
        always_comb begin
            if (run_now[g]) begin
                run_next[g] = !halt_i[g];
            end else begin
                run_next[g] = irq_i[g];
            end
        end
    end

    assign next_o = lpm_mode_e'(run_next);

    assert_both_halt_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (base_i == LPM_MT && halt_i == 2'b11) |-> next_o == LPM_ALL_HALTED);

    assert_wake_halted_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        ((base_i == LPM_ST0 && irq_i[1]) || (base_i == LPM_ST1 && irq_i[0]))
        |-> !(halt_i != 2'b00) || next_o != LPM_ALL_HALTED);

    assert_idle_wake_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (base_i == LPM_ALL_HALTED) |-> $countones(next_o) == $countones(irq_i));

endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
    import lp_mode_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       drained_i,
    input  lpm_mode_e  eval_i,
    output lpm_mode_e  base_o,
    output lpm_mode_e  mode_o,
    output seq_state_e state_o
);

    seq_state_e state_q, state_d;
    lpm_mode_e  mode_q,  mode_d;
    lpm_mode_e  tgt_q,   tgt_d;

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEQ_STEADY;
            mode_q  <= LPM_MT;
            tgt_q   <= LPM_MT;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            tgt_q   <= tgt_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        tgt_d   = tgt_q;
        unique case (state_q)
            SEQ_STEADY: begin
                if (eval_i != mode_q) begin
                    state_d = SEQ_DRAIN;
                    tgt_d   = eval_i;
                end
            end
            SEQ_DRAIN: begin
                tgt_d = eval_i;
                if (drained_i) begin
                    mode_d  = eval_i;
                    state_d = SEQ_STEADY;
                end
            end
            default: state_d = SEQ_STEADY;
        endcase
    end

    // Outputs.
    always_comb begin
        base_o  = (state_q == SEQ_DRAIN) ? tgt_q : mode_q;
        mode_o  = mode_q;
        state_o = state_q;
    end

    assert_hold_without_ack_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !(state_q == SEQ_DRAIN && drained_i) |=> $stable(mode_q));

    assert_req_persists_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SEQ_DRAIN && !drained_i) |=> state_q == SEQ_DRAIN);

    assert_commit_on_ack_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SEQ_DRAIN && drained_i)
        |=> (state_q == SEQ_STEADY && mode_q == $past(eval_i)));

    assert_quiet_when_settled_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SEQ_STEADY && eval_i == mode_q) |=> state_q == SEQ_STEADY);

    assert_ack_ignored_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SEQ_STEADY) |=> $stable(mode_q));

endmodule

// File: rtl/lp_mode_decode.sv
module lp_mode_decode
    import lp_mode_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  lpm_mode_e         mode_i,
    input  seq_state_e        state_i,
    output logic [LP_NUM-1:0] active_o,
    output logic              repart_req_o
);

    always_comb begin
        unique case (mode_i)
            LPM_MT:         active_o = 2'b11;
            LPM_ST0:        active_o = 2'b01;
            LPM_ST1:        active_o = 2'b10;
            LPM_ALL_HALTED: active_o = 2'b00;
            default:        active_o = 2'b00;
        endcase
        repart_req_o = (state_i == SEQ_DRAIN);
    end

    assert_flags_follow_mode_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !repart_req_o |=> $stable(active_o));

endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
    import lp_mode_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [LP_NUM-1:0] halt_i,
    input  logic [LP_NUM-1:0] irq_i,
    input  logic              drained_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [LP_NUM-1:0] active_o,
    output logic              repart_req_o
);

    lpm_mode_e  base_mode;
    lpm_mode_e  eval_mode;
    lpm_mode_e  cur_mode;
    seq_state_e seq_state;

    lp_run_eval u_eval (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .base_i (base_mode),
        .halt_i (halt_i),
        .irq_i  (irq_i),
        .next_o (eval_mode)
    );

    lp_mode_seq u_seq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .drained_i (drained_i),
        .eval_i    (eval_mode),
        .base_o    (base_mode),
        .mode_o    (cur_mode),
        .state_o   (seq_state)
    );

    lp_mode_decode u_dec (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .mode_i       (cur_mode),
        .state_i      (seq_state),
        .active_o     (active_o),
        .repart_req_o (repart_req_o)
    );

    assign mode_o = cur_mode;

endmodule

// File: tb/lp_mode_ctrl_tb.sv
module lp_mode_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] halt, irq;
    logic       drained;
    logic [1:0] mode, active;
    logic       req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [1:0] m_mode, m_tgt;
    logic       m_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_mode_ctrl u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .halt_i       (halt),
        .irq_i        (irq),
        .drained_i    (drained),
        .mode_o       (mode),
        .active_o     (active),
        .repart_req_o (req)
    );

    function automatic logic [1:0] next_run(logic [1:0] run, logic [1:0] h, logic [1:0] i);
        logic [1:0] r;
        for (int t = 0; t < 2; t++) r[t] = run[t] ? !h[t] : i[t];
        return r;
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {mode,active,req} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(logic [1:0] h, logic [1:0] i, logic d, string tag);
        logic [1:0] t;
        halt = h; irq = i; drained = d;
        @(posedge clk);
        if (!m_req) begin
            t = next_run(m_mode, h, i);
            if (t != m_mode) begin m_req = 1'b1; m_tgt = t; end
        end else begin
            t = next_run(m_tgt, h, i);
            if (d) begin m_mode = t; m_req = 1'b0; end
            else m_tgt = t;
        end
        @(negedge clk);
        check(tag, {mode, active, req}, {m_mode, m_mode, m_req});
    endtask

    task automatic do_reset();
        rst = 1'b1; halt = '0; irq = '0; drained = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mode = 2'b11; m_tgt = 2'b11; m_req = 1'b0;
        check("R1", {mode, active, req}, 5'b11_11_0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();

        // R8: drained without request does nothing.
        step(2'b00, 2'b00, 1'b1, "R8");
        check("R8", {mode, active, req}, 5'b11_11_0);
        // R5: interrupts to running threads in MT ignored.
        step(2'b00, 2'b11, 1'b0, "R5");
        check("R5", {mode, active, req}, 5'b11_11_0);

        // R2: thread 0 halts -> ST1; request held until drained (R7).
        step(2'b01, 2'b00, 1'b0, "R7");
        check("R7", {mode, active, req}, 5'b11_11_1);
        step(2'b00, 2'b00, 1'b0, "R7");
        step(2'b00, 2'b00, 1'b1, "R2");
        check("R2", {mode, active, req}, 5'b10_10_0);

        // R5: halt from halted thread 0, irq to running thread 1.
        step(2'b01, 2'b10, 1'b0, "R5");
        check("R5", {mode, active, req}, 5'b10_10_0);

        // R4: irq to halted thread 0 -> MT.
        step(2'b00, 2'b01, 1'b0, "R4");
        step(2'b00, 2'b00, 1'b1, "R4");
        check("R4", {mode, active, req}, 5'b11_11_0);

        // R2: thread 1 halts -> ST0.
        step(2'b10, 2'b00, 1'b1, "R2");
        step(2'b00, 2'b00, 1'b1, "R2");
        check("R2", {mode, active, req}, 5'b01_01_0);

        // R6: lone thread 0 halts -> ALL_HALTED.
        step(2'b01, 2'b00, 1'b0, "R6");
        step(2'b00, 2'b00, 1'b1, "R6");
        check("R6", {mode, active, req}, 5'b00_00_0);

        // R6: irq thread 1 -> ST1.
        step(2'b00, 2'b10, 1'b0, "R6");
        step(2'b00, 2'b00, 1'b1, "R6");
        check("R6", {mode, active, req}, 5'b10_10_0);

        // R4: irq thread 0 -> MT; R3: both halt -> ALL_HALTED.
        step(2'b00, 2'b01, 1'b1, "R4");
        step(2'b00, 2'b00, 1'b1, "R4");
        step(2'b11, 2'b00, 1'b0, "R3");
        step(2'b00, 2'b00, 1'b1, "R3");
        check("R3", {mode, active, req}, 5'b00_00_0);

        // R6: both woken -> MT.
        step(2'b00, 2'b11, 1'b0, "R6");
        step(2'b00, 2'b00, 1'b1, "R6");
        check("R6", {mode, active, req}, 5'b11_11_0);

        // R9: retarget during request, then back to old mode on ack cycle.
        step(2'b01, 2'b00, 1'b0, "R9");
        step(2'b00, 2'b01, 1'b1, "R9");
        check("R9", {mode, active, req}, 5'b11_11_0);
        step(2'b10, 2'b00, 1'b0, "R9");
        step(2'b01, 2'b00, 1'b1, "R9");
        check("R9", {mode, active, req}, 5'b00_00_0);

        // Reset mid-request returns to MT.
        step(2'b00, 2'b01, 1'b0, "R10");
        do_reset();

        // Random phase.
        for (int n = 0; n < 600; n++) begin
            logic [1:0] h, i;
            logic d;
            h = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
            i = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
            d = ($urandom_range(0, 2) == 0);
            step(h, i, d, "R10");
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule